// File: doc/BRIEF.md
# Bundle Lane Legality Gate

This block sits at the decode stage of a small long-instruction-word core that issues up to three instructions per bundle. Decode has already reduced every lane to a class tag. For each candidate bundle the gate decides whether the lanes may issue together under the current execution mode. When they may not, it does not raise a trap. It grants lane 1 alone, so the members issue one at a time on later cycles. This is safe because a bundle's parallel result has to equal its sequential result.

The execution mode is a small register inside the gate, written by the mode-set class of instruction. Bundles enter on a valid/ready stream and decisions leave on a second valid/ready stream through one register stage. A bundle is taken when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so back-pressure on `out_ready` stalls the input with no loss. A decision stays on the outputs, unchanged, until `out_ready` takes it.

Top module: `lane_bundle_gate`

## Requirements
- R1: After reset `out_valid` is low, `in_ready` is high, and the mode register holds the scalar mode (0).
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R3: In mode 0 every bundle with more than one valid lane is reported with `out_issue_par`=0.
- R4: Class codes on each 4-bit lane field are: 0 plain ALU, 1 shift, 2 convert, 3 light convert, 4 memory, 5 FPU, 6 branch, 7 128-bit pair move, 8 mode-set, 9 compare, and 10 to 15 other. A legal bundle with two or more valid lanes gives `out_issue_par`=1 and sets `out_issue_mask` to the lane valid bits. Any other bundle gives `out_issue_par`=0 and `out_issue_mask`=001.
- R5: In mode 1, lane 3 is never granted. Lane 2 may hold only classes 0 to 3.
- R6: In mode 1, a memory or pair-move op in lane 1 takes both lanes, so it cannot be paired. Either op alone is accepted.
- R7: In mode 2, lane 2 may hold classes 0 to 3, or an FPU op, provided lane 1 is not also an FPU op.
- R8: In mode 2, lane 3 may hold only classes 0 and 3. A memory or pair-move op in lane 1 takes lane 3, so lane 3 must then be empty.
- R9: Memory, branch, compare, pair-move, mode-set and other classes are granted only in lane 1.
- R10: A mode-set in any valid lane loads its lane's 2-bit argument into the mode register. The argument takes effect from the next bundle. The bundle carrying the mode-set is judged under the old mode and reports it on `out_mode`. If several lanes carry one, the highest lane wins.
- R11: A stored mode value of 3 acts as mode 0, and `out_mode` then reads 0.
- R12: A bundle with only lane 1 valid is reported with `out_issue_par`=0 and mask 001 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Candidate bundle present |
| in_ready | output | 1 | Gate can take a bundle |
| in_lane_vld | input | 3 | Lane valid bits, bit 0 is lane 1 |
| in_lane_cls | input | 12 | Class tag per lane, 4 bits each, bits 3:0 are lane 1 |
| in_lane_arg | input | 6 | Mode-set argument per lane, 2 bits each |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Consumer takes the decision |
| out_issue_par | output | 1 | Bundle issues in parallel |
| out_issue_mask | output | 3 | Lanes granted this cycle |
| out_mode | output | 2 | Effective mode the bundle was judged under |

## Verification
The assertions take the input bundles as packed. Lane 1 is valid whenever the bundle is, and a lane is valid only if every lower lane is. Under that assumption a granted mask is either the lone lane 1 bit or two or more bits. The stimulus builds every bundle from the valid patterns 001, 011 and 111 only. It never raises `in_valid` with lane 1 empty, and it holds each bundle steady until the handshake completes.

// File: rtl/lanechk_pkg.sv
package lanechk_pkg;
  localparam int LANES  = 3;
  localparam int CLS_W  = 4;
  localparam int MODE_W = 2;
  localparam int CLS_BUS_W = LANES * CLS_W;
  localparam int ARG_BUS_W = LANES * MODE_W;

  localparam logic [CLS_W-1:0] K_ALU      = 4'd0;
  localparam logic [CLS_W-1:0] K_SHIFT    = 4'd1;
  localparam logic [CLS_W-1:0] K_CONV     = 4'd2;
  localparam logic [CLS_W-1:0] K_CONVLITE = 4'd3;
  localparam logic [CLS_W-1:0] K_MEM      = 4'd4;
  localparam logic [CLS_W-1:0] K_FPU      = 4'd5;
  localparam logic [CLS_W-1:0] K_BRANCH   = 4'd6;
  localparam logic [CLS_W-1:0] K_MOV128   = 4'd7;
  localparam logic [CLS_W-1:0] K_MODESET  = 4'd8;
  localparam logic [CLS_W-1:0] K_CMP      = 4'd9;

  localparam logic [MODE_W-1:0] M_SCALAR = 2'd0;
  localparam logic [MODE_W-1:0] M_PAIR   = 2'd1;
  localparam logic [MODE_W-1:0] M_TRIPLE = 2'd2;
endpackage

// File: rtl/lanechk_slot_decode.sv
module lanechk_slot_decode
  import lanechk_pkg::*;
#(
  parameter int SLOT = 0
) (
  input  logic [CLS_W-1:0] cls,
  output logic             ok_pair,
  output logic             ok_triple,
  output logic             is_mem,
  output logic             is_fpu,
  output logic             is_mset
);
  logic basic;

  always_comb begin
    basic   = (cls == K_ALU) || (cls == K_SHIFT) || (cls == K_CONV) || (cls == K_CONVLITE);
    is_mem  = (cls == K_MEM) || (cls == K_MOV128);
    is_fpu  = (cls == K_FPU);
    is_mset = (cls == K_MODESET);
  end

  generate
    if (SLOT == 0) begin : g_head
      assign ok_pair   = 1'b1;
      assign ok_triple = 1'b1;
    end else if (SLOT == 1) begin : g_mid
      assign ok_pair   = basic;
      assign ok_triple = basic || is_fpu;
    end else begin : g_tail
      assign ok_pair   = 1'b0;
      assign ok_triple = (cls == K_ALU) || (cls == K_CONVLITE);
    end
  endgenerate
endmodule

// File: rtl/lanechk_judge.sv
module lanechk_judge
  import lanechk_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [LANES-1:0]  vld,
  input  logic [LANES-1:0]  ok_pair,
  input  logic [LANES-1:0]  ok_triple,
  input  logic              head_mem,
  input  logic              head_fpu,
  input  logic              mid_fpu,
  output logic              par,
  output logic [LANES-1:0]  mask
);
  localparam logic [LANES-1:0] HEAD_ONLY = LANES'(1);

  logic multi;
  logic pair_fit;
  logic triple_fit;
  logic legal;
  int   cnt;

  always_comb begin
    cnt = 0;
    for (int i = 0; i < LANES; i++) cnt += int'(vld[i]);
    multi = (cnt > 1);

    pair_fit = !vld[2] && ok_pair[0] &&
               (!vld[1] || (ok_pair[1] && !head_mem));

    triple_fit = ok_triple[0] &&
                 (!vld[1] || (ok_triple[1] && !(mid_fpu && head_fpu))) &&
                 (!vld[2] || (ok_triple[2] && !head_mem));

    unique case (mode)
      M_PAIR:   legal = pair_fit;
      M_TRIPLE: legal = triple_fit;
      default:  legal = 1'b0;
    endcase

    par  = multi && legal;
    mask = par ? vld : HEAD_ONLY;
  end
endmodule

// File: rtl/lanechk_mode_reg.sv
module lanechk_mode_reg
  import lanechk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic [LANES-1:0]     vld,
  input  logic [LANES-1:0]     mset,
  input  logic [ARG_BUS_W-1:0] args,
  output logic [MODE_W-1:0]    mode_eff
);
  logic [MODE_W-1:0] raw_q;
  logic [MODE_W-1:0] raw_d;

  always_comb begin
    raw_d = raw_q;
    for (int i = 0; i < LANES; i++) begin
      if (vld[i] && mset[i]) raw_d = args[i*MODE_W +: MODE_W];
    end
    mode_eff = (raw_q > M_TRIPLE) ? M_SCALAR : raw_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    raw_q <= M_SCALAR;
    else if (take) raw_q <= raw_d;
  end
endmodule

// File: rtl/lane_bundle_gate.sv
module lane_bundle_gate
  import lanechk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [LANES-1:0]     in_lane_vld,
  input  logic [CLS_BUS_W-1:0] in_lane_cls,
  input  logic [ARG_BUS_W-1:0] in_lane_arg,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_issue_par,
  output logic [LANES-1:0]     out_issue_mask,
  output logic [MODE_W-1:0]    out_mode
);
  logic [LANES-1:0]  ok_pair, ok_triple, is_mem, is_fpu, is_mset;
  logic [MODE_W-1:0] mode_now;
  logic              par_d;
  logic [LANES-1:0]  mask_d;
  logic              take;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_slot
      lanechk_slot_decode #(.SLOT(g)) u_dec (
        .cls       (in_lane_cls[g*CLS_W +: CLS_W]),
        .ok_pair   (ok_pair[g]),
        .ok_triple (ok_triple[g]),
        .is_mem    (is_mem[g]),
        .is_fpu    (is_fpu[g]),
        .is_mset   (is_mset[g])
      );
    end
  endgenerate

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  lanechk_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .vld      (in_lane_vld),
    .mset     (is_mset),
    .args     (in_lane_arg),
    .mode_eff (mode_now)
  );

  lanechk_judge u_judge (
    .mode      (mode_now),
    .vld       (in_lane_vld),
    .ok_pair   (ok_pair),
    .ok_triple (ok_triple),
    .head_mem  (is_mem[0]),
    .head_fpu  (is_fpu[0]),
    .mid_fpu   (is_fpu[1]),
    .par       (par_d),
    .mask      (mask_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_issue_par  <= 1'b0;
      out_issue_mask <= '0;
      out_mode       <= M_SCALAR;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_issue_par  <= par_d;
        out_issue_mask <= mask_d;
        out_mode       <= mode_now;
      end
    end
  end
endmodule

// File: rtl/lane_bundle_gate_chk.sv
module lane_bundle_gate_chk
  import lanechk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_issue_par,
  input logic [LANES-1:0]  out_issue_mask,
  input logic [MODE_W-1:0] out_mode
);
  a_r4_fallback_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_issue_par) |-> (out_issue_mask == LANES'(1)));

  a_r4_parallel_width: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_issue_par) |-> ($countones(out_issue_mask) >= 2));

  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_issue_par) &&
                                   $stable(out_issue_mask) && $stable(out_mode)));

  a_r3_scalar_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mode == M_SCALAR) |-> !out_issue_par);

  a_r5_pair_no_third: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mode == M_PAIR) |-> !out_issue_mask[2]);

  a_r11_mode_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mode <= M_TRIPLE));
endmodule

bind lane_bundle_gate lane_bundle_gate_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_issue_par  (out_issue_par),
  .out_issue_mask (out_issue_mask),
  .out_mode       (out_mode)
);

// File: tb/lane_bundle_gate_test.sv
`timescale 1ns/1ps
module lane_bundle_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_lane_vld = '0;
  logic [11:0] in_lane_cls = '0;
  logic [5:0]  in_lane_arg = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_issue_par;
  logic [2:0]  out_issue_mask;
  logic [1:0]  out_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic       par;
    logic [2:0] mask;
    logic [1:0] mode;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [1:0] mdl_mode = 2'd0;

  always #2 clk = ~clk;

  lane_bundle_gate uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_lane_vld(in_lane_vld), .in_lane_cls(in_lane_cls), .in_lane_arg(in_lane_arg),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_issue_par(out_issue_par), .out_issue_mask(out_issue_mask), .out_mode(out_mode)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference rules written from the requirements.
  function automatic bit lane2_in(logic [1:0] m, logic [3:0] c);
    if (m == 2'd1) return c <= 4'd3;
    return (c <= 4'd3) || (c == 4'd5);
  endfunction

  function automatic bit lane3_in(logic [3:0] c);
    return (c == 4'd0) || (c == 4'd3);
  endfunction

  task automatic send(logic [2:0] v, logic [3:0] c0, logic [3:0] c1, logic [3:0] c2,
                      logic [1:0] a0, logic [1:0] a1, logic [1:0] a2, string tag);
    exp_t e;
    logic [1:0] m;
    bit ok;
    bit wide;
    m = (mdl_mode == 2'd3) ? 2'd0 : mdl_mode;
    wide = (c0 == 4'd4) || (c0 == 4'd7);
    ok = 1'b0;
    if (v != 3'b001) begin
      if (m == 2'd1)
        ok = !v[2] && lane2_in(m, c1) && !wide;
      else if (m == 2'd2)
        ok = lane2_in(m, c1) && !(c0 == 4'd5 && c1 == 4'd5) &&
             (!v[2] || (lane3_in(c2) && !wide));
    end
    e.par  = ok;
    e.mask = ok ? v : 3'b001;
    e.mode = m;
    e.tag  = tag;
    sb.push_back(e);
    if (v[0] && c0 == 4'd8) mdl_mode = a0;
    if (v[1] && c1 == 4'd8) mdl_mode = a1;
    if (v[2] && c2 == 4'd8) mdl_mode = a2;

    @(posedge clk); #1;
    in_valid    = 1'b1;
    in_lane_vld = v;
    in_lane_cls = {c2, c1, c0};
    in_lane_arg = {a2, a1, a0};
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // Scoreboard monitor plus stall stability check.
  bit         held = 0;
  logic       h_par;
  logic [2:0] h_mask;
  logic [1:0] h_mode;
  always @(negedge clk) begin
    if (rst_n) begin
      check(in_ready == (!out_valid || out_ready), "R2", "in_ready", in_ready, !out_valid || out_ready);
      if (held && out_valid)
        check(out_issue_par == h_par && out_issue_mask == h_mask && out_mode == h_mode,
              "R2", "stalled output changed mask", out_issue_mask, h_mask);
      held = 0;
      if (out_valid && !out_ready) begin
        held = 1; h_par = out_issue_par; h_mask = out_issue_mask; h_mode = out_mode;
      end
      if (out_valid && out_ready) begin
        if (sb.size() == 0) check(0, "R4", "unexpected output", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(out_issue_par == e.par, e.tag, "par", out_issue_par, e.par);
          check(out_issue_mask == e.mask, e.tag, "mask", out_issue_mask, e.mask);
          check(out_mode == e.mode, e.tag, "mode", out_mode, e.mode);
        end
      end
    end
  end

  initial begin
    #(4ns * 200000);
    if (!done) begin
      check(0, "R1", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // Mode 0 (R1 reset mode, R3, R12)
    send(3'b111, 0, 0, 0, 0, 0, 0, "R3");
    send(3'b011, 0, 1, 0, 0, 0, 0, "R3");
    send(3'b001, 4, 0, 0, 0, 0, 0, "R12");

    // R10: mode-set judged under old mode, effect next bundle
    send(3'b001, 8, 0, 0, 1, 0, 0, "R10");
    send(3'b011, 0, 1, 0, 0, 0, 0, "R5");
    send(3'b111, 0, 0, 0, 0, 0, 0, "R5");
    send(3'b011, 0, 5, 0, 0, 0, 0, "R5");
    send(3'b011, 6, 2, 0, 0, 0, 0, "R5");
    send(3'b011, 4, 0, 0, 0, 0, 0, "R6");
    send(3'b001, 7, 0, 0, 0, 0, 0, "R6");
    send(3'b011, 7, 3, 0, 0, 0, 0, "R6");
    send(3'b011, 0, 6, 0, 0, 0, 0, "R9");
    send(3'b001, 3, 0, 0, 0, 0, 0, "R12");
    send(3'b011, 8, 0, 0, 2, 0, 0, "R10");

    // Mode 2 (R7, R8, R9)
    send(3'b111, 0, 1, 0, 0, 0, 0, "R8");
    send(3'b111, 0, 0, 1, 0, 0, 0, "R8");
    send(3'b111, 0, 2, 3, 0, 0, 0, "R8");
    send(3'b111, 0, 0, 2, 0, 0, 0, "R8");
    send(3'b011, 5, 5, 0, 0, 0, 0, "R7");
    send(3'b011, 0, 5, 0, 0, 0, 0, "R7");
    send(3'b011, 4, 5, 0, 0, 0, 0, "R7");
    send(3'b111, 4, 0, 0, 0, 0, 0, "R8");
    send(3'b011, 4, 0, 0, 0, 0, 0, "R8");
    send(3'b111, 7, 0, 0, 0, 0, 0, "R8");
    send(3'b111, 9, 0, 3, 0, 0, 0, "R9");
    send(3'b011, 0, 9, 0, 0, 0, 0, "R9");
    send(3'b111, 0, 0, 4, 0, 0, 0, "R9");
    send(3'b011, 0, 12, 0, 0, 0, 0, "R9");

    // R10 highest lane wins
    send(3'b011, 8, 8, 0, 0, 1, 0, "R10");
    send(3'b111, 0, 1, 0, 0, 0, 0, "R10");
    // R11 value 3 acts as mode 0
    send(3'b001, 8, 0, 0, 3, 0, 0, "R11");
    send(3'b011, 0, 0, 0, 0, 0, 0, "R11");
    send(3'b001, 8, 0, 0, 2, 0, 0, "R11");

    // R2 back-pressure
    fork
      begin
        @(posedge clk); #1 out_ready = 1'b0;
        repeat (6) @(posedge clk);
        #1 out_ready = 1'b1;
      end
      begin
        send(3'b111, 0, 1, 3, 0, 0, 0, "R2");
        send(3'b011, 5, 5, 0, 0, 0, 0, "R2");
        send(3'b011, 0, 2, 0, 0, 0, 0, "R2");
      end
    join

    // Mixed traffic with random back-pressure
    fork
      begin
        for (int k = 0; k < 300; k++) begin
          @(posedge clk); #1 out_ready = ($urandom_range(3) != 0);
        end
        @(posedge clk); #1 out_ready = 1'b1;
      end
      begin
        for (int k = 0; k < 200; k++) begin
          int sel;
          logic [2:0] v;
          sel = $urandom_range(2);
          v = (sel == 0) ? 3'b001 : (sel == 1) ? 3'b011 : 3'b111;
          send(v, 4'($urandom_range(10)), 4'($urandom_range(10)), 4'($urandom_range(10)),
               2'($urandom_range(3)), 2'($urandom_range(3)), 2'($urandom_range(3)), "R4");
        end
      end
    join

    repeat (20) @(posedge clk);
    check(sb.size() == 0, "R4", "decisions left undelivered", sb.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule